// File: doc/BRIEF.md
# Banked File Register Address Mapper

This block turns the five-bit register field of an instruction into a physical byte address inside a 144-byte data store, and it holds that store. The field reaches register numbers 00h to 1Fh. Numbers 00h to 0Fh map to one shared window of sixteen bytes. Numbers 10h to 1Fh map to one of eight banked windows of sixteen bytes, and the three top bits of the file select value choose the bank. Register number 00h has no storage behind it. Using it turns the access indirect: the low five bits of the file select value then name the register, and the bank bits still apply.

The lowest eight register numbers belong to special-function registers, such as the port data latches at 05h to 07h. These live outside this block. An access that lands on 01h to 07h raises a flag so that an external handler can serve it, and the general-purpose array is left untouched. An indirect access whose pointer names register 00h reads as zero and drops any write. Reads are registered, so data appears one clock after the read strobe.

Top module: `banked_fr_mapper`

## Requirements
- R1: For a nonzero operand below 10h, phys_addr equals the operand's low four bits (0..15), whatever the file select value holds.
- R2: For an operand from 10h to 1Fh, phys_addr equals 16 + 16*fsr[7:5] + operand[3:0] (range 16..143).
- R3: indirect_hit is high exactly when the operand is 00h. The effective register number is then fsr[4:0], and it is mapped by the rules of R1 and R2 with the same bank bits.
- R4: When the effective register number is 01h to 07h, sfr_hit is high. A write leaves the array unchanged, and a read returns 00h.
- R5: When the operand is 00h and fsr[4:0] is 00h, a read returns 00h and a write is ignored. sfr_hit stays low.
- R6: A write to a general-purpose location (effective number 08h..1Fh) stores wr_data at phys_addr on the clock edge. A later read of the same location returns it on rd_data one cycle after the read strobe.
- R7: rd_data keeps its value in every cycle in which rd_en is low.
- R8: When a read and a write hit the same location in one cycle, the read returns the value held before the write.
- R9: After reset, rd_data is 00h and every store location reads 00h.
- R10: Locations 08h..0Fh are one shared set of bytes. A value written under one bank selection reads back under any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opnd | input | 5 | Register field of the instruction |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| fsr | input | 8 | Current file select value |
| phys_addr | output | 8 | Physical store address |
| rd_data | output | 8 | Registered read data |
| indirect_hit | output | 1 | Operand used the indirect alias |
| sfr_hit | output | 1 | Effective register is special-function |

## Verification
The bench goes after bank aliasing. It writes under one bank and reads under another. A mapper that applied the bank bits to the shared window, or ignored them in the upper window, would return stale or foreign bytes. It also drives indirect pointers of 00h with nonzero bank bits, where a design that treated only the whole file select value 00h as null would store data. Further cases are writes to special-function numbers, which a careless design would let corrupt the low array bytes, and a read and a write to the same address in one cycle, which would expose write-first forwarding.

// File: rtl/bfr_pkg.sv
package bfr_pkg;
    typedef enum logic [1:0] {
        ACC_GP   = 2'd0,
        ACC_SFR  = 2'd1,
        ACC_NULL = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/bfr_decode.sv
module bfr_decode
    import bfr_pkg::*;
#(
    parameter int OPND_W    = 5,
    parameter int DATA_W    = 8,
    parameter int BANKS     = 8,
    parameter int BANK_SPAN = 16,
    parameter int SFR_CNT   = 8,
    parameter int AW        = 8
) (
    input  logic [OPND_W-1:0] opnd,
    input  logic [DATA_W-1:0] fsr,
    output logic [AW-1:0]     phys_addr,
    output acc_kind_e         kind,
    output logic              indirect
);
    localparam int BANK_W = $clog2(BANKS);
    localparam int OFF_W  = $clog2(BANKS > 0 ? BANK_SPAN : 1);

    logic [OPND_W-1:0] eff_d;
    logic [BANK_W-1:0] bank_d;

    always_comb begin
        indirect = (opnd == '0);
        eff_d    = indirect ? fsr[OPND_W-1:0] : opnd;
        bank_d   = fsr[DATA_W-1 -: BANK_W];
        if (eff_d[OPND_W-1]) begin
            phys_addr = AW'(BANK_SPAN) + AW'(bank_d) * AW'(BANK_SPAN)
                      + AW'(eff_d[OFF_W-1:0]);
        end else begin
            phys_addr = AW'(eff_d[OFF_W-1:0]);
        end
        if (eff_d == '0) begin
            kind = ACC_NULL;
        end else if (int'(eff_d) < SFR_CNT) begin
            kind = ACC_SFR;
        end else begin
            kind = ACC_GP;
        end
    end
endmodule

// File: rtl/bfr_store.sv
module bfr_store
    import bfr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 144,
    parameter int AW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  acc_kind_e         kind,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [DATA_W-1:0]            rd;
    } store_t;

    store_t st_d, st_q;
    logic   gp_ok;

    always_comb begin
        st_d  = st_q;
        gp_ok = (kind == ACC_GP) && (int'(addr) < DEPTH);
        if (rd_en) begin
            st_d.rd = gp_ok ? st_q.mem[addr] : '0;
        end
        if (wr_en && gp_ok) begin
            st_d.mem[addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rd;
endmodule

// File: rtl/banked_fr_mapper.sv
module banked_fr_mapper
    import bfr_pkg::*;
#(
    parameter int OPND_W    = 5,
    parameter int DATA_W    = 8,
    parameter int BANKS     = 8,
    parameter int BANK_SPAN = 16,
    parameter int SFR_CNT   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPND_W-1:0] opnd,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] fsr,
    output logic [7:0]        phys_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              indirect_hit,
    output logic              sfr_hit
);
    localparam int DEPTH = BANK_SPAN * (BANKS + 1);
    localparam int AW    = 8;

    acc_kind_e kind_w;

    bfr_decode #(
        .OPND_W(OPND_W), .DATA_W(DATA_W), .BANKS(BANKS),
        .BANK_SPAN(BANK_SPAN), .SFR_CNT(SFR_CNT), .AW(AW)
    ) u_decode (
        .opnd(opnd), .fsr(fsr), .phys_addr(phys_addr),
        .kind(kind_w), .indirect(indirect_hit)
    );

    bfr_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .addr(phys_addr), .kind(kind_w),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    assign sfr_hit = (kind_w == ACC_SFR);
endmodule

// File: rtl/banked_fr_mapper_chk.sv
module banked_fr_mapper_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] opnd,
    input logic       rd_en,
    input logic [7:0] fsr,
    input logic [7:0] phys_addr,
    input logic [7:0] rd_data,
    input logic       indirect_hit,
    input logic       sfr_hit
);
    assert_low_shared_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (opnd != 5'd0 && !opnd[4]) |-> (phys_addr == {4'd0, opnd[3:0]}));

    assert_upper_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        opnd[4] |-> (phys_addr >= 8'd16 && phys_addr < 8'd144));

    assert_indirect_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        indirect_hit == (opnd == 5'd0));

    assert_sfr_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sfr_hit) |=> (rd_data == 8'd0));

    assert_null_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && opnd == 5'd0 && fsr[4:0] == 5'd0) |=> (rd_data == 8'd0));

    assert_null_no_sfr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (opnd == 5'd0 && fsr[4:0] == 5'd0) |-> !sfr_hit);

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

bind banked_fr_mapper banked_fr_mapper_chk u_chk (
    .clk(clk), .rst_n(rst_n), .opnd(opnd), .rd_en(rd_en), .fsr(fsr),
    .phys_addr(phys_addr), .rd_data(rd_data),
    .indirect_hit(indirect_hit), .sfr_hit(sfr_hit)
);

// File: tb/banked_fr_mapper_bench.sv
module banked_fr_mapper_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] opnd = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] fsr = '0;
    logic [7:0] phys_addr;
    logic [7:0] rd_data;
    logic       indirect_hit;
    logic       sfr_hit;

    int n_chk = 0;
    int n_fail = 0;
    int model_mem [144];
    int model_rd = 0;

    always #4 clk = ~clk;

    banked_fr_mapper u_banked_fr_mapper (
        .clk(clk), .rst_n(rst_n), .opnd(opnd), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .fsr(fsr), .phys_addr(phys_addr), .rd_data(rd_data),
        .indirect_hit(indirect_hit), .sfr_hit(sfr_hit)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int eff_reg(input int op, input int f);
        return (op == 0) ? (f % 32) : op;
    endfunction

    function automatic int ref_addr(input int op, input int f);
        int r = eff_reg(op, f);
        if (r >= 16) return 16 + (f / 32) * 16 + (r - 16);
        return r;
    endfunction

    // one access: drive, check decode, clock, update model, check read data
    task automatic access(input string tag, input int op, input int f,
                          input bit rd, input bit wr, input int wd);
        int a;
        int r;
        bit gp;
        opnd = op[4:0]; fsr = f[7:0]; rd_en = rd; wr_en = wr; wr_data = wd[7:0];
        #1;
        a = ref_addr(op, f);
        r = eff_reg(op, f);
        gp = (r >= 8);
        check({tag, " addr R1/R2"}, int'(phys_addr), a);
        check({tag, " indirect R3"}, int'(indirect_hit), (op == 0) ? 1 : 0);
        check({tag, " sfr R4"}, int'(sfr_hit), (r >= 1 && r <= 7) ? 1 : 0);
        @(posedge clk);
        if (rd) model_rd = gp ? model_mem[a] : 0;
        if (wr && gp) model_mem[a] = wd % 256;
        @(negedge clk);
        check({tag, " rd_data R6/R7/R8"}, int'(rd_data), model_rd);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        foreach (model_mem[i]) model_mem[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("reset rd_data R9", int'(rd_data), 0);
        access("R9 fresh upper", 5'h1F, 8'hE0, 1, 0, 0);
        access("R9 fresh low", 5'h08, 8'h00, 1, 0, 0);

        // R2: bank 4 write of 64h at 10h
        access("R2 write bank4", 5'h10, 8'h90, 0, 1, 8'h64);
        access("R2 read bank4", 5'h10, 8'h90, 1, 0, 0);
        access("R2 other bank", 5'h10, 8'h00, 1, 0, 0);
        // R3: indirect read of the same location
        access("R3 indirect read", 5'h00, 8'h90, 1, 0, 0);
        access("R3 indirect write", 5'h00, 8'hF5, 0, 1, 8'hA7);
        access("R3 direct readback", 5'h15, 8'hE0, 1, 0, 0);
        // R10 and R1: shared low window
        access("R10 write bank3", 5'h0A, 8'h60, 0, 1, 8'h3C);
        access("R10 read bank6", 5'h0A, 8'hC0, 1, 0, 0);
        access("R1 indirect low", 5'h00, 8'h2A, 1, 0, 0);
        // R4: special-function numbers
        access("R4 write sfr", 5'h05, 8'h00, 0, 1, 8'hFF);
        access("R4 read sfr", 5'h05, 8'h00, 1, 0, 0);
        access("R4 indirect sfr", 5'h00, 8'hE7, 1, 1, 8'h11);
        // R5: null pointer with bank bits set
        access("R5 null write", 5'h00, 8'h20, 0, 1, 8'h55);
        access("R5 null read", 5'h00, 8'h20, 1, 0, 0);
        access("R5 low after null", 5'h10, 8'h20, 1, 0, 0);
        // R7: idle hold
        access("R6 load", 5'h1C, 8'h40, 1, 1, 8'h9E);
        access("R7 idle", 5'h1C, 8'h40, 0, 0, 0);
        access("R7 idle write", 5'h1C, 8'h40, 0, 1, 8'h12);
        // R8: read old value while writing
        access("R8 rd+wr", 5'h1C, 8'h40, 1, 1, 8'h77);
        access("R8 after", 5'h1C, 8'h40, 1, 0, 0);
        // R2/R6 sweep of every bank and offset
        for (int b = 0; b < 8; b++) begin
            for (int o = 16; o < 32; o++) begin
                access("R6 sweep wr", o, b * 32, 0, 1, (b * 16 + o) ^ 8'h5A);
            end
        end
        for (int o = 8; o < 16; o++) begin
            access("R6 sweep low", o, 8'h00, 0, 1, o * 3);
        end
        for (int b = 0; b < 8; b++) begin
            for (int o = 0; o < 32; o++) begin
                access("R6 sweep rd", o, b * 32 + (o % 32), 1, 0, 0);
            end
        end
        // R9: reset clears the store
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        foreach (model_mem[i]) model_mem[i] = 0;
        model_rd = 0;
        check("R9 reset again", int'(rd_data), 0);
        access("R9 cleared upper", 5'h1C, 8'h40, 1, 0, 0);
        access("R9 cleared low", 5'h0A, 8'h00, 1, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule